// File: doc/BRIEF.md
# DMA Request Routing Mux with Periodic Triggering

This block takes a 64-line vector of peripheral DMA request signals and routes them onto a smaller set of DMA channel request outputs. Each output channel has its own 8-bit configuration word. The word holds an enable bit, a trigger-mode bit and a 6-bit source number that picks one of the 64 request lines. Source number 0 and a parameterised set of reserved numbers (50 to 57 by default) are illegal, and a channel that selects one of them stays quiet. The top source numbers (58 to 63 by default) are always-on requestors. They count as requesting whatever their input line does.

The low channels (0 to 7 by default) can also run in trigger mode. In this mode a pulse on the channel's own tick input arms a one-shot latch. The selected request then reaches the output for exactly one cycle, which gives one DMA request per tick period without software involvement. The higher channels do plain routing only, and they neither store nor act on the trigger-mode bit.

Software configures the block through a plain register write/read port. To change a channel while the system runs, software clears its enable bit, writes the new source and then sets enable again. All request and tick inputs are plain level or pulse signals with no handshake. The channel outputs are combinational from the stored configuration, the request vector and the arm latch.

Top module: `dmx_route_top`

## Requirements
- R1: After reset every configuration word reads back as 0x00 and every channel output is low, even with all source inputs high.
- R2: An enabled channel in plain routing mode with a legal source number drives its output equal to that source's input line in the same cycle.
- R3: Source number 0 and the reserved numbers 50 to 57 keep the channel output low whatever the inputs are.
- R4: Source numbers 58 to 63 assert an enabled plain-mode channel's output with every source input low.
- R5: While the enable bit (bit 7) is 0 the channel output is low, whatever the source field and the inputs hold.
- R6: In trigger mode (bit 6 set) on channels 0 to 7, the output stays low until a tick pulse has been latched. It then asserts for exactly one cycle while the source requests, after which it needs a new tick.
- R7: Tick input n arms only channel n.
- R8: Tick pulses that arrive while a channel is disabled or has trigger mode off are discarded.
- R9: Channels 8 to 15 ignore the trigger-mode bit. They route plainly, and that bit reads back as 0.
- R10: A configuration read returns enable in bit 7, trigger mode in bit 6 and the source number in bits 5:0.
- R11: An armed trigger-mode channel whose source is idle keeps its arm until the source requests, then passes exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for a configuration word |
| cfg_wr_ch | input | 4 | Channel whose word is written |
| cfg_wr_data | input | 8 | Word: bit 7 enable, bit 6 trigger mode, bits 5:0 source |
| cfg_rd_ch | input | 4 | Channel whose word is read |
| cfg_rd_data | output | 8 | Stored word of the addressed channel |
| src_req | input | 64 | Peripheral request lines, indexed by source number |
| tick_in | input | 8 | Periodic trigger pulses, one per trigger-capable channel |
| dma_req | output | 16 | Routed request per DMA channel |

## Verification
Routing is swept over all 64 source numbers on one plain channel with three input patterns. A one-hot line on the chosen source separates legal from illegal codes. An all-zero vector isolates the always-on codes. An inverted one-hot vector, with every line high except the chosen one, shows that no channel listens to a neighbouring line. A table of single-channel cases covers the enable bit, the readback format and trigger-mode channels that receive no tick. Directed tick sequences then tell apart a one-shot pass from a level pass, the channel's own tick from a neighbour's, an arm held across an idle source, and ticks discarded while gating is off.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int SEL_W   = 6;
  localparam int NUM_SRC = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic             tmode;
    logic [SEL_W-1:0] src;
  } dmx_cfg_t;

  localparam int CFG_W = $bits(dmx_cfg_t);

  function automatic logic [NUM_SRC-1:0] always_on_mask(input int first);
    logic [NUM_SRC-1:0] m;
    for (int i = 0; i < NUM_SRC; i++) m[i] = (i >= first);
    return m;
  endfunction
endpackage

// File: rtl/dmx_cfg_regs.sv
module dmx_cfg_regs
  import dmx_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int NUM_TRIG = 8,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CH_W-1:0]      wr_ch,
  input  logic [CFG_W-1:0]     wr_data,
  input  logic [CH_W-1:0]      rd_ch,
  output logic [CFG_W-1:0]     rd_data,
  output dmx_cfg_t             cfg [NUM_CH]
);
  dmx_cfg_t wr_word;
  assign wr_word = dmx_cfg_t'(wr_data);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[c].en  <= 1'b0;
        cfg[c].src <= '0;
      end else if (sel) begin
        cfg[c].en  <= wr_word.en;
        cfg[c].src <= wr_word.src;
      end
    end

    if (c < NUM_TRIG) begin : g_tbit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cfg[c].tmode <= 1'b0;
        else if (sel) cfg[c].tmode <= wr_word.tmode;
      end
    end else begin : g_notbit
      assign cfg[c].tmode = 1'b0;
    end
  end

  assign rd_data = cfg[rd_ch];
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
  import dmx_pkg::*;
#(
  parameter bit HAS_TRIG    = 1'b1,
  parameter int ALWAYS_FIRST = 58
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dmx_cfg_t           cfg,
  input  logic [NUM_SRC-1:0] eff_req,
  input  logic [NUM_SRC-1:0] legal,
  input  logic               trig,
  output logic               out
);
  logic hit, gate_on, armed_q, armed_d;

  assign hit     = cfg.en && legal[cfg.src] && eff_req[cfg.src];
  assign gate_on = HAS_TRIG && cfg.en && cfg.tmode;
  assign out     = gate_on ? (hit && armed_q) : hit;

  always_comb begin
    if (!gate_on)     armed_d = 1'b0;
    else if (out)     armed_d = trig;
    else              armed_d = armed_q || trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !legal[cfg.src] |-> !out); // R3
  AST_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !gate_on && (int'(cfg.src) >= ALWAYS_FIRST)) |-> out); // R4
  AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !out); // R5
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (out && gate_on && !trig) |=> !(out && gate_on)); // R6
  AST_ARM_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(trig)); // R6
  AST_DISCARD_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> !armed_q); // R8
endmodule

// File: rtl/dmx_route_top.sv
module dmx_route_top
  import dmx_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int NUM_TRIG     = 8,
  parameter int ALWAYS_FIRST = 58,
  parameter logic [63:0] RSVD_MASK = 64'h03FC_0000_0000_0000,
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [CH_W-1:0]      cfg_wr_ch,
  input  logic [CFG_W-1:0]     cfg_wr_data,
  input  logic [CH_W-1:0]      cfg_rd_ch,
  output logic [CFG_W-1:0]     cfg_rd_data,
  input  logic [NUM_SRC-1:0]   src_req,
  input  logic [NUM_TRIG-1:0]  tick_in,
  output logic [NUM_CH-1:0]    dma_req
);
  localparam logic [NUM_SRC-1:0] ALWAYS_MASK = always_on_mask(ALWAYS_FIRST);
  localparam logic [NUM_SRC-1:0] LEGAL_MASK  =
    ~NUM_SRC'(RSVD_MASK) & ~NUM_SRC'(1);

  dmx_cfg_t           cfg [NUM_CH];
  logic [NUM_SRC-1:0] eff_req;

  assign eff_req = src_req | ALWAYS_MASK;

  dmx_cfg_regs #(.NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_ch   (cfg_wr_ch),
    .wr_data (cfg_wr_data),
    .rd_ch   (cfg_rd_ch),
    .rd_data (cfg_rd_data),
    .cfg     (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic tk;
    if (c < NUM_TRIG) begin : g_tk
      assign tk = tick_in[c];
    end else begin : g_notk
      assign tk = 1'b0;
    end

    dmx_chan #(.HAS_TRIG(c < NUM_TRIG), .ALWAYS_FIRST(ALWAYS_FIRST)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg[c]),
      .eff_req (eff_req),
      .legal   (LEGAL_MASK),
      .trig    (tk),
      .out     (dma_req[c])
    );
  end
endmodule

// File: tb/tb_dmx_route_top.sv
module tb_dmx_route_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_ch = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic [3:0]  cfg_rd_ch = '0;
  logic [7:0]  cfg_rd_data;
  logic [63:0] src_req = '0;
  logic [7:0]  tick_in = '0;
  logic [15:0] dma_req;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dmx_route_top dut (.*);

  // {req tag, channel, config word, drive selected line, expected output}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {4'd2,  4'd2,  8'h85, 1'b1, 1'b1},
    {4'd2,  4'd2,  8'h85, 1'b0, 1'b0},
    {4'd5,  4'd3,  8'h05, 1'b1, 1'b0},
    {4'd3,  4'd4,  8'h80, 1'b1, 1'b0},
    {4'd3,  4'd4,  8'hB2, 1'b1, 1'b0},
    {4'd3,  4'd4,  8'hB9, 1'b1, 1'b0},
    {4'd4,  4'd5,  8'hBA, 1'b0, 1'b1},
    {4'd4,  4'd5,  8'hBF, 1'b0, 1'b1},
    {4'd9,  4'd12, 8'hC7, 1'b1, 1'b1},
    {4'd2,  4'd15, 8'hB1, 1'b1, 1'b1},
    {4'd6,  4'd0,  8'hC7, 1'b1, 1'b0},
    {4'd5,  4'd5,  8'h3F, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ch, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_ch = ch; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #2;
  endtask

  task automatic tick(input logic [7:0] t);
    @(negedge clk); tick_in = t;
    @(negedge clk); tick_in = '0;
    #2;
  endtask

  task automatic step;
    @(negedge clk); #2;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    src_req = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < 16; c++) begin
      cfg_rd_ch = 4'(c); #1;
      chk("R1 readback", 32'(cfg_rd_data), 32'h0);
    end
    chk("R1 outputs", 32'(dma_req), 32'h0);
    rst_n = 1'b1;
    step;
    chk("R1 after release", 32'(dma_req), 32'h0);
    src_req = '0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] tag, ch; logic [7:0] w; logic drv, ex;
      {tag, ch, w, drv, ex} = VEC[i];
      wr(ch, w);
      src_req = drv ? (64'd1 << w[5:0]) : 64'd0;
      #1;
      chk($sformatf("R%0d table entry %0d", tag, i), 32'(dma_req), 32'(ex) << ch);
      wr(ch, 8'h00);
      src_req = '0;
    end

    // Sweep all sources on plain channel 9: R2 legal, R3 illegal, R4 always-on
    for (int s = 0; s < 64; s++) begin
      bit legal_s, always_s;
      legal_s  = (s != 0) && !(s >= 50 && s <= 57);
      always_s = (s >= 58);
      wr(4'd9, 8'h80 | 8'(s));
      src_req = 64'd1 << s; #1;
      chk(legal_s ? "R2 one-hot" : "R3 one-hot", 32'(dma_req), legal_s ? 32'h200 : 32'h0);
      src_req = '0; #1;
      chk("R4 all-low", 32'(dma_req), always_s ? 32'h200 : 32'h0);
      src_req = ~(64'd1 << s); #1;
      chk("R2 inverted one-hot", 32'(dma_req), always_s ? 32'h200 : 32'h0);
      src_req = '0;
    end
    wr(4'd9, 8'h00);

    // R10 / R9 readback
    wr(4'd6, 8'hEB);
    cfg_rd_ch = 4'd6; #1;
    chk("R10 readback ch6", 32'(cfg_rd_data), 32'hEB);
    wr(4'd11, 8'hEB);
    cfg_rd_ch = 4'd11; #1;
    chk("R9 readback ch11 trigger bit", 32'(cfg_rd_data), 32'hAB);
    wr(4'd6, 8'h00); wr(4'd11, 8'h00);

    // R6 one-shot on channel 3, source 10
    wr(4'd3, 8'hCA);
    src_req = 64'd1 << 10; #1;
    chk("R6 no tick yet", 32'(dma_req), 32'h0);
    @(negedge clk); tick_in = 8'h08; #2;
    chk("R6 tick cycle", 32'(dma_req), 32'h0);
    @(negedge clk); tick_in = '0; #2;
    chk("R6 pass cycle", 32'(dma_req), 32'h8);
    step;
    chk("R6 single cycle", 32'(dma_req), 32'h0);
    step;
    chk("R6 stays low", 32'(dma_req), 32'h0);

    // R7 tick to its own channel only
    wr(4'd4, 8'hCA);
    tick(8'h10);
    chk("R7 tick4 -> ch4 only", 32'(dma_req), 32'h10);
    step;
    chk("R7 after pass", 32'(dma_req), 32'h0);

    // R11 arm held across idle source
    src_req = '0;
    tick(8'h08);
    step; step;
    chk("R11 armed idle", 32'(dma_req), 32'h0);
    src_req = 64'd1 << 10; #1;
    chk("R11 pass on request", 32'(dma_req), 32'h8);
    step;
    chk("R11 single pass", 32'(dma_req), 32'h0);

    // R8 ticks discarded with trigger mode off, then with enable low
    src_req = '0;
    wr(4'd3, 8'h8A);
    tick(8'h08);
    wr(4'd3, 8'hCA);
    src_req = 64'd1 << 10; #1;
    chk("R8 tmode off discard", 32'(dma_req), 32'h0);
    src_req = '0;
    wr(4'd3, 8'h4A);
    tick(8'h08);
    wr(4'd3, 8'hCA);
    src_req = 64'd1 << 10; #1;
    chk("R8 disabled discard", 32'(dma_req), 32'h0);
    step;
    chk("R8 still idle", 32'(dma_req), 32'h0);

    // R5 reconfiguration procedure on plain channel 10
    src_req = 64'd1 << 20;
    wr(4'd10, 8'h94);
    chk("R5 before reconfig", 32'(dma_req), 32'h400);
    wr(4'd10, 8'h14);
    chk("R5 disabled", 32'(dma_req), 32'h0);
    wr(4'd10, 8'h21);
    chk("R5 new source disabled", 32'(dma_req), 32'h0);
    src_req = 64'd1 << 33;
    wr(4'd10, 8'hA1);
    chk("R5 re-enabled new source", 32'(dma_req), 32'h400);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule